// File: doc/BRIEF.md
# Receive Clock Phase-Tracking Loop

This block recovers a nominal 1.536 MHz bit clock from a faster free-running reference clock. It does so with a programmable divider whose output is a one-cycle clock enable, `rclk_en`. With the default reference of 15.36 MHz, a nominal recovered period is 10 reference ticks.

A line receiver elsewhere detects the framing transition in the incoming signal and reports it as a one-cycle strobe. The loop records where that strobe falls within the divider phase. It then corrects the recovered clock by stretching or shrinking exactly one output period by a single reference tick, which is 65 ns at the default rates. Only one such decision is taken per tracking interval. The default interval is 250 µs, or 3840 ticks.

`frame_tick` marks the end of each tracking interval. Two sticky flags report the direction of the last decision, and each `frame_tick` clears them. When `track_en` is low, the divider free-runs at its nominal period. In a system with several receive channels, only the selected channel has its enable raised.

Top module: `rx_clk_tracker`

## Requirements
- R1: While reset is held and in the cycle reset is released, `rclk_en` is 1 (divider phase 0), and `frame_tick`, `early_flag` and `late_flag` are 0. In the next cycle `rclk_en` is 0.
- R2: When no strobe is accepted, `rclk_en` is high for one cycle every DIV_NOM (10) cycles.
- R3: `frame_tick` is high for one cycle every INTERVAL_TICKS cycles.
- R4: The strobe phase is the number of cycles since the cycle in which `rclk_en` was high; that cycle itself is phase 0. An accepted strobe at phase 1 to DIV_NOM/2-1 (1..4) makes the next recovered period DIV_NOM-1 (9) cycles long and sets `late_flag` one cycle later.
- R5: With MID_TO_LONG=1, an accepted strobe at phase DIV_NOM/2 to DIV_NOM-1 (5..9) makes the next period DIV_NOM+1 (11) cycles long and sets `early_flag`. For phase DIV_NOM-1, the next period is the one that starts in the following cycle.
- R6: An accepted strobe at phase 0 leaves the following period at DIV_NOM cycles and sets no flag.
- R7: Only the first strobe seen while `track_en` is high in a tracking interval is evaluated. Later strobes in the same interval change neither the period lengths nor the flags.
- R8: The flags are sticky and clear in the cycle after `frame_tick`, unless a strobe is evaluated in the `frame_tick` cycle itself.
- R9: While `track_en` is low, strobes are ignored: periods stay at DIV_NOM cycles and no flag is set.
- R10: `early_flag` and `late_flag` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock (DIV_NOM × bit rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| track_en | input | 1 | Enables phase tracking for this channel |
| fl_strobe | input | 1 | One-cycle pulse at the received framing transition |
| rclk_en | output | 1 | One-cycle enable per recovered bit period |
| frame_tick | output | 1 | One-cycle pulse ending each tracking interval |
| early_flag | output | 1 | Sticky: last decision lengthened a period |
| late_flag | output | 1 | Sticky: last decision shortened a period |

## Verification
`rclk_en` is decoded straight from the divider state, so a period change caused by a strobe at phase p first shows on the next `rclk_en` pulse. That pulse comes 10−p cycles later, or in the very next cycle for p = 9. The bench therefore measures the length of the whole period that follows, counting falling edges from one pulse to the next. The flags register one cycle after the strobe, and the bench samples them several cycles after that. They clear one cycle after `frame_tick`, and the bench checks them on the falling edge right after the `frame_tick` sample. All inputs change on falling edges, so every strobe is seen at a known phase.

// File: rtl/rxdpll_pkg.sv
package rxdpll_pkg;
   typedef enum logic [1:0] {
      CORR_NONE  = 2'd0,
      CORR_SHORT = 2'd1,
      CORR_LONG  = 2'd2
   } corr_e;
endpackage

// File: rtl/rxdpll_interval_timer.sv
module rxdpll_interval_timer #(
   parameter int INTERVAL_TICKS = 3840
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int IV_W = (INTERVAL_TICKS > 2) ? $clog2(INTERVAL_TICKS) : 1;
   localparam bit IS_POW2 = ((INTERVAL_TICKS & (INTERVAL_TICKS - 1)) == 0);
   localparam logic [IV_W-1:0] LAST = IV_W'(INTERVAL_TICKS - 1);

   logic [IV_W-1:0] cnt;

   generate
      if (INTERVAL_TICKS < 2) begin : g_bad
         $error("INTERVAL_TICKS must be at least 2");
      end
      if (IS_POW2) begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n) cnt <= '0;
            else        cnt <= cnt + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (!rst_n)           cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   assign tick = (cnt == LAST);

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R3
endmodule

// File: rtl/rxdpll_phase_detect.sv
module rxdpll_phase_detect
   import rxdpll_pkg::*;
#(
   parameter int DIV_NOM     = 10,
   parameter bit MID_TO_LONG = 1'b1,
   parameter int PH_W        = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            track_en,
   input  logic            fl_strobe,
   input  logic [PH_W-1:0] ph,
   input  logic            tick,
   output corr_e           corr_req,
   output logic            early_flag,
   output logic            late_flag
);
   localparam logic [PH_W-1:0] HALF = PH_W'(DIV_NOM / 2);

   logic decided;
   logic eval;
   logic is_short;

   assign eval = track_en && fl_strobe && !decided;

   generate
      if (MID_TO_LONG) begin : g_mid_long
         assign is_short = (ph != '0) && (ph < HALF);
      end else begin : g_mid_short
         assign is_short = (ph != '0) && (ph <= HALF);
      end
   endgenerate

   always_comb begin
      corr_req = CORR_NONE;
      if (eval && ph != '0) corr_req = is_short ? CORR_SHORT : CORR_LONG;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         decided    <= 1'b0;
         early_flag <= 1'b0;
         late_flag  <= 1'b0;
      end else begin
         decided <= tick ? 1'b0 : (decided || eval);
         if (tick) begin
            early_flag <= (corr_req == CORR_LONG);
            late_flag  <= (corr_req == CORR_SHORT);
         end else begin
            early_flag <= early_flag || (corr_req == CORR_LONG);
            late_flag  <= late_flag  || (corr_req == CORR_SHORT);
         end
      end
   end

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(early_flag && late_flag)); // R10
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(fl_strobe && track_en)) |=> (!early_flag && !late_flag)); // R8
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!track_en && !early_flag && !late_flag) |=> (!early_flag && !late_flag)); // R9
endmodule

// File: rtl/rxdpll_divider.sv
module rxdpll_divider
   import rxdpll_pkg::*;
#(
   parameter int DIV_NOM = 10,
   parameter int PH_W    = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            track_en,
   input  corr_e           corr_req,
   output logic [PH_W-1:0] ph,
   output logic            rclk_en
);
   localparam logic [PH_W-1:0] LEN_NOM   = PH_W'(DIV_NOM);
   localparam logic [PH_W-1:0] LEN_SHORT = PH_W'(DIV_NOM - 1);
   localparam logic [PH_W-1:0] LEN_LONG  = PH_W'(DIV_NOM + 1);

   logic [PH_W-1:0] cur_len;
   corr_e           pending;
   corr_e           next_pend;
   logic            wrap;
   logic [PH_W-1:0] next_len;

   assign wrap      = (ph == cur_len - 1'b1);
   assign next_pend = (corr_req != CORR_NONE) ? corr_req : pending;

   always_comb begin
      next_len = LEN_NOM;
      if (track_en) begin
         case (next_pend)
            CORR_SHORT: next_len = LEN_SHORT;
            CORR_LONG:  next_len = LEN_LONG;
            default:    next_len = LEN_NOM;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph      <= '0;
         cur_len <= LEN_NOM;
         pending <= CORR_NONE;
      end else if (wrap) begin
         ph      <= '0;
         cur_len <= next_len;
         pending <= CORR_NONE;
      end else begin
         ph      <= ph + 1'b1;
         pending <= track_en ? next_pend : CORR_NONE;
      end
   end

   assign rclk_en = (ph == '0);

   AST_PERIOD_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_len == LEN_NOM) || (cur_len == LEN_SHORT) || (cur_len == LEN_LONG)); // R4
   AST_PH_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      ph < cur_len); // R2
   AST_NO_CORR_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !track_en) |=> (cur_len == LEN_NOM)); // R9
endmodule

// File: rtl/rx_clk_tracker.sv
module rx_clk_tracker
   import rxdpll_pkg::*;
#(
   parameter int DIV_NOM        = 10,
   parameter int INTERVAL_TICKS = 3840,
   parameter bit MID_TO_LONG    = 1'b1
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic track_en,
   input  logic fl_strobe,
   output logic rclk_en,
   output logic frame_tick,
   output logic early_flag,
   output logic late_flag
);
   localparam int PH_W = $clog2(DIV_NOM + 2);

   generate
      if (DIV_NOM < 4) begin : g_bad_div
         $error("DIV_NOM must be at least 4");
      end
      if (INTERVAL_TICKS < 4 * DIV_NOM) begin : g_bad_iv
         $error("INTERVAL_TICKS must cover several recovered periods");
      end
   endgenerate

   logic [PH_W-1:0] ph;
   corr_e           corr_req;

   rxdpll_interval_timer #(
      .INTERVAL_TICKS(INTERVAL_TICKS)
   ) u_timer (
      .clk   (clk_ref),
      .rst_n (rst_n),
      .tick  (frame_tick)
   );

   rxdpll_phase_detect #(
      .DIV_NOM     (DIV_NOM),
      .MID_TO_LONG (MID_TO_LONG),
      .PH_W        (PH_W)
   ) u_detect (
      .clk        (clk_ref),
      .rst_n      (rst_n),
      .track_en   (track_en),
      .fl_strobe  (fl_strobe),
      .ph         (ph),
      .tick       (frame_tick),
      .corr_req   (corr_req),
      .early_flag (early_flag),
      .late_flag  (late_flag)
   );

   rxdpll_divider #(
      .DIV_NOM (DIV_NOM),
      .PH_W    (PH_W)
   ) u_div (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .track_en (track_en),
      .corr_req (corr_req),
      .ph       (ph),
      .rclk_en  (rclk_en)
   );

   AST_RESET_PHASE: assert property (@(posedge clk_ref)
      !rst_n |=> rclk_en); // R1
endmodule

// File: tb/rx_clk_tracker_tb.sv
`timescale 1ns/1ps
module rx_clk_tracker_tb;
   localparam int NOM = 10;
   localparam int IVL = 100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic track_en = 1'b0;
   logic fl_strobe = 1'b0;
   logic rclk_en, frame_tick, early_flag, late_flag;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rx_clk_tracker #(
      .DIV_NOM(NOM), .INTERVAL_TICKS(IVL), .MID_TO_LONG(1'b1)
   ) u_dut (
      .clk_ref(clk), .rst_n(rst_n), .track_en(track_en), .fl_strobe(fl_strobe),
      .rclk_en(rclk_en), .frame_tick(frame_tick),
      .early_flag(early_flag), .late_flag(late_flag)
   );

   // vector table: strobe phase, expected following period, expected flag (0 none, 1 late, 2 early)
   localparam int NV = 7;
   localparam int VP[NV]   = '{0, 1, 4, 3, 5, 7, 9};
   localparam int VLEN[NV] = '{10, 9, 9, 9, 11, 11, 11};
   localparam int VFLG[NV] = '{0, 1, 1, 1, 2, 2, 2};

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_rclk();
      @(negedge clk);
      while (rclk_en !== 1'b1) @(negedge clk);
   endtask

   task automatic wait_tick();
      @(negedge clk);
      while (frame_tick !== 1'b1) @(negedge clk);
   endtask

   task automatic pulse_at(input int p);
      repeat (p) @(negedge clk);
      fl_strobe = 1'b1;
      @(negedge clk);
      fl_strobe = 1'b0;
   endtask

   // from a negedge at which rclk_en is high, count cycles to the next pulse
   task automatic measure(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (rclk_en !== 1'b1);
   endtask

   task automatic start_of_period();
      if (rclk_en !== 1'b1) wait_rclk();
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      chk("R1 rclk_en in reset", int'(rclk_en), 1);
      rst_n = 1'b1;
      track_en = 1'b1;
      chk("R1 rclk_en at release", int'(rclk_en), 1);
      chk("R1 frame_tick at release", int'(frame_tick), 0);
      chk("R1 flags at release", int'({early_flag, late_flag}), 0);
      @(negedge clk);
      chk("R1 rclk_en after first edge", int'(rclk_en), 0);

      // R2: nominal periods with no strobe
      wait_tick();
      wait_rclk();
      measure(n);
      chk("R2 nominal period a", n, NOM);
      measure(n);
      chk("R2 nominal period b", n, NOM);

      // R3: interval spacing
      wait_tick();
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (frame_tick !== 1'b1);
      chk("R3 interval length", n, IVL);

      // table of phase vectors: R4 R5 R6 R10
      for (int i = 0; i < NV; i++) begin
         wait_tick();
         wait_rclk();
         pulse_at(VP[i]);
         start_of_period();
         measure(n);
         chk($sformatf("R4/R5/R6 period after phase %0d", VP[i]), n, VLEN[i]);
         chk($sformatf("R4 late_flag after phase %0d", VP[i]), int'(late_flag),
             (VFLG[i] == 1) ? 1 : 0);
         chk($sformatf("R5 early_flag after phase %0d", VP[i]), int'(early_flag),
             (VFLG[i] == 2) ? 1 : 0);
         chk("R10 flags exclusive", int'(early_flag && late_flag), 0);
      end

      // R8: flags clear after tick
      wait_tick();
      @(negedge clk);
      chk("R8 flags cleared after tick", int'({early_flag, late_flag}), 0);

      // R7: second strobe in the same interval ignored
      wait_rclk();
      pulse_at(2);
      wait_rclk();
      pulse_at(7);
      wait_rclk();
      measure(n);
      chk("R7 period after ignored strobe", n, NOM);
      chk("R7 early_flag untouched", int'(early_flag), 0);
      chk("R7 late_flag from first strobe", int'(late_flag), 1);

      // R8 again, late flag cleared
      wait_tick();
      @(negedge clk);
      chk("R8 late_flag cleared", int'(late_flag), 0);

      // R9: tracking disabled
      track_en = 1'b0;
      wait_tick();
      wait_rclk();
      pulse_at(3);
      wait_rclk();
      measure(n);
      chk("R9 period with tracking off", n, NOM);
      chk("R9 flags with tracking off", int'({early_flag, late_flag}), 0);
      track_en = 1'b1;

      // R6: strobe at phase 0 yields nominal and no flag (directed repeat)
      wait_tick();
      wait_rclk();
      pulse_at(0);
      start_of_period();
      measure(n);
      chk("R6 phase zero period", n, NOM);
      chk("R6 phase zero flags", int'({early_flag, late_flag}), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule